// File: doc/BRIEF.md
# Endian-Selectable Sub-Word Load/Store Aligner

This block sits between a 32-bit register datapath and a memory built from 32-bit words with byte addressing. For a store it takes a register value and an access size (byte, halfword or word). It moves the meaningful bytes onto the memory byte lanes that the low address bits select, and it raises one write enable for each lane it fills. For a load it takes the word read from memory, picks out the addressed byte, halfword or word, and returns it right-aligned. A sub-word result is extended to 32 bits, with zeros or with copies of its sign bit.

A mode input picks big-endian or little-endian order for each access. The memory bus itself never changes: lane i always holds the byte at word offset i. Endianness only decides which lane carries the most significant part of an access. An access whose address is not a multiple of its size is refused. The block flags it and writes nothing.

Every result is registered once, so all outputs follow the request by one clock. Internally each request is classified into one of four access phases. `PH_IDLE` means no request. `PH_STORE` means an aligned store. `PH_LOAD` means an aligned load. `PH_FAULT` means a refused access. The phase decides which output register captures a new value. There are no transitions between phases: each cycle's request fixes the phase afresh.

Top module: `endian_lsu_aligner`

## Requirements
- R1: Lane i (bits 8i+7..8i) of `wr_word` and `rd_word`, and bit i of `byte_en`, belong to the byte at offset i inside the word (`addr_lo` = i). Size codes are 0 = byte, 1 = halfword, 2 = word and 3 = illegal. Every output reflects the request of the previous clock.
- R2: With `big_endian` = 0, the least significant byte of an access sits at its lowest address. A word store of 0x12345678 at offset 0 gives `wr_word` = 0x12345678. Halfword loads from offsets 0 and 2 of that word return 0x5678 and 0x1234.
- R3: With `big_endian` = 1, the most significant byte of an access sits at its lowest address. A word store of 0x12345678 gives `wr_word` = 0x78563412, and halfword loads from offsets 0 and 2 return 0x1234 and 0x5678. After a word store of 5, a byte load from offset 0 returns 0 and one from offset 3 returns 5.
- R4: An aligned store raises exactly one `byte_en` bit for a byte, two adjacent bits for a halfword and all four for a word, each on the lanes the address covers. Lanes that are not enabled carry zero in `wr_word`.
- R5: A load with `ld_signed` = 1 fills bits above the loaded byte or halfword with that item's top bit.
- R6: A load with `ld_signed` = 0 fills bits above the loaded byte or halfword with zeros.
- R7: A halfword access at an odd offset, a word access at a nonzero offset, or size code 3 sets `misalign` to 1. In that cycle `byte_en`, `wr_word` and `ld_data` are all zero, so memory is left unchanged.
- R8: A load never raises `byte_en`. A cycle with `req_valid` = 0 gives all-zero outputs, with `misalign` = 0.
- R9: While `rst_n` is low, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Access size code (0 byte, 1 halfword, 2 word, 3 illegal) |
| ld_signed | input | 1 | Sign-extend the loaded item |
| big_endian | input | 1 | 1 = most significant byte at the lowest address |
| addr_lo | input | 2 | Byte offset inside the word |
| st_data | input | 32 | Register value to store, right-aligned |
| rd_word | input | 32 | Word read from memory for a load |
| wr_word | output | 32 | Lane-aligned store data |
| byte_en | output | 4 | Per-lane write enables |
| ld_data | output | 32 | Extended load result |
| misalign | output | 1 | Request refused for misalignment |

## Verification
Each result is due on the first rising edge after its request is presented, and no output shows a combinational path from the inputs. The bench applies every request on a falling edge and computes the expected outputs from a behavioural byte-memory model at the same moment. It compares all four outputs on the next falling edge, exactly one clock after the request, before it drives the next request. Requests follow each other on every clock, so a result that arrives a cycle early or late shows up as a mismatch against its neighbour's expectation. The checker's properties look one clock ahead with `|=>` for the same reason.

// File: rtl/aln_pkg.sv
package aln_pkg;

    // Access size codes: number of bytes is 2**code.
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    // Per-cycle classification of a request.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_STORE = 2'd1,
        PH_LOAD  = 2'd2,
        PH_FAULT = 2'd3
    } acc_phase_e;

endpackage

// File: rtl/aln_access_check.sv
module aln_access_check #(
    parameter  int LANES = 4,
    localparam int OFF_W = $clog2(LANES)
) (
    input  logic [1:0]       size,
    input  logic [OFF_W-1:0] addr_lo,
    output logic             misaligned
);
    localparam int MAX_CODE = $clog2(LANES);

    int nbytes;

    always_comb begin
        nbytes = 1 << size;
        if (int'(size) > MAX_CODE) begin
            misaligned = 1'b1;
        end else begin
            misaligned = ((int'(addr_lo) % nbytes) != 0);
        end
    end

endmodule

// File: rtl/aln_store_steer.sv
module aln_store_steer #(
    parameter  int LANES  = 4,
    localparam int DATA_W = LANES * 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [1:0]        size,
    input  logic              big_end,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] st_data,
    output logic [DATA_W-1:0] wr_word,
    output logic [LANES-1:0]  lane_en
);
    int nbytes;

    always_comb begin
        nbytes = 1 << size;
    end

    // One steering mux per memory lane: lane i takes the source byte whose
    // position inside the access maps onto address offset i.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [7:0] lane_byte;
        logic       lane_hit;
        int         rel;
        int         sig;

        always_comb begin
            rel       = i - int'(addr_lo);
            sig       = 0;
            lane_byte = 8'h00;
            lane_hit  = 1'b0;
            if (rel >= 0 && rel < nbytes) begin
                sig = big_end ? (nbytes - 1 - rel) : rel;
                if (sig < LANES) begin
                    lane_byte = st_data[sig*8 +: 8];
                    lane_hit  = 1'b1;
                end
            end
        end

        assign wr_word[i*8 +: 8] = lane_byte;
        assign lane_en[i]        = lane_hit;
    end

endmodule

// File: rtl/aln_load_extract.sv
module aln_load_extract #(
    parameter  int LANES  = 4,
    localparam int DATA_W = LANES * 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic [1:0]        size,
    input  logic              sign_ext,
    input  logic              big_end,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] ld_data
);
    int   nbytes;
    int   top_lane;
    logic fill;

    // The item's most significant byte lives at the lowest offset in
    // big-endian order and at the highest covered offset otherwise.
    always_comb begin
        nbytes   = 1 << size;
        top_lane = big_end ? int'(addr_lo) : int'(addr_lo) + nbytes - 1;
        fill     = 1'b0;
        if (sign_ext && top_lane < LANES) begin
            fill = rd_word[top_lane*8 + 7];
        end
    end

    // Result byte s (significance s) is gathered from the matching lane,
    // or filled when it lies above the loaded item.
    for (genvar s = 0; s < LANES; s++) begin : g_sig
        logic [7:0] res_byte;
        int         src;

        always_comb begin
            src      = big_end ? (int'(addr_lo) + nbytes - 1 - s) : (int'(addr_lo) + s);
            res_byte = {8{fill}};
            if (s < nbytes) begin
                res_byte = 8'h00;
                if (src >= 0 && src < LANES) begin
                    res_byte = rd_word[src*8 +: 8];
                end
            end
        end

        assign ld_data[s*8 +: 8] = res_byte;
    end

endmodule

// File: rtl/endian_lsu_aligner.sv
module endian_lsu_aligner
    import aln_pkg::*;
#(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [1:0]        req_size,
    input  logic              ld_signed,
    input  logic              big_endian,
    input  logic [OFF_W-1:0]  addr_lo,
    input  logic [DATA_W-1:0] st_data,
    input  logic [DATA_W-1:0] rd_word,
    output logic [DATA_W-1:0] wr_word,
    output logic [LANES-1:0]  byte_en,
    output logic [DATA_W-1:0] ld_data,
    output logic              misalign
);
    logic              bad_align;
    logic [DATA_W-1:0] steer_word;
    logic [LANES-1:0]  steer_en;
    logic [DATA_W-1:0] extract_word;

    acc_phase_e        phase_c;

    logic [DATA_W-1:0] wr_word_d;
    logic [LANES-1:0]  byte_en_d;
    logic [DATA_W-1:0] ld_data_d;
    logic              misalign_d;

    aln_access_check #(.LANES(LANES)) u_check (
        .size       (req_size),
        .addr_lo    (addr_lo),
        .misaligned (bad_align)
    );

    aln_store_steer #(.LANES(LANES)) u_store (
        .size    (req_size),
        .big_end (big_endian),
        .addr_lo (addr_lo),
        .st_data (st_data),
        .wr_word (steer_word),
        .lane_en (steer_en)
    );

    aln_load_extract #(.LANES(LANES)) u_load (
        .size     (req_size),
        .sign_ext (ld_signed),
        .big_end  (big_endian),
        .addr_lo  (addr_lo),
        .rd_word  (rd_word),
        .ld_data  (extract_word)
    );

    // Request classification.
    always_comb begin
        if (!req_valid) begin
            phase_c = PH_IDLE;
        end else if (bad_align) begin
            phase_c = PH_FAULT;
        end else if (req_store) begin
            phase_c = PH_STORE;
        end else begin
            phase_c = PH_LOAD;
        end
    end

    // Output selection per phase.
    always_comb begin
        wr_word_d  = '0;
        byte_en_d  = '0;
        ld_data_d  = '0;
        misalign_d = 1'b0;
        unique case (phase_c)
            PH_IDLE: begin
            end
            PH_STORE: begin
                wr_word_d = steer_word;
                byte_en_d = steer_en;
            end
            PH_LOAD: begin
                ld_data_d = extract_word;
            end
            PH_FAULT: begin
                misalign_d = 1'b1;
            end
            default: begin
            end
        endcase
    end

    // Output register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_word  <= '0;
            byte_en  <= '0;
            ld_data  <= '0;
            misalign <= 1'b0;
        end else begin
            wr_word  <= wr_word_d;
            byte_en  <= byte_en_d;
            ld_data  <= ld_data_d;
            misalign <= misalign_d;
        end
    end

endmodule

// File: rtl/endian_lsu_aligner_chk.sv
module endian_lsu_aligner_chk #(
    parameter  int DATA_W = 32,
    localparam int LANES  = DATA_W / 8,
    localparam int OFF_W  = $clog2(LANES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_store,
    input logic [1:0]        req_size,
    input logic              ld_signed,
    input logic              big_endian,
    input logic [OFF_W-1:0]  addr_lo,
    input logic [DATA_W-1:0] st_data,
    input logic [DATA_W-1:0] rd_word,
    input logic [DATA_W-1:0] wr_word,
    input logic [LANES-1:0]  byte_en,
    input logic [DATA_W-1:0] ld_data,
    input logic              misalign
);

    p_byte_store_one_lane_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd0) |=> ($countones(byte_en) == 1));

    p_half_store_two_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd1 && !addr_lo[0]) |=> ($countones(byte_en) == 2));

    p_word_store_all_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store && req_size == 2'd2 && addr_lo == '0) |=> (&byte_en));

    p_odd_half_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd1 && addr_lo[0]) |=> (misalign && byte_en == '0 && wr_word == '0 && ld_data == '0));

    p_rsvd_size_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_size == 2'd3) |=> (misalign && byte_en == '0));

    p_load_no_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store) |=> (byte_en == '0));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid) |=> (!misalign && byte_en == '0 && ld_data == '0 && wr_word == '0));

    p_signed_byte_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && req_size == 2'd0 && ld_signed)
        |=> (ld_data[DATA_W-1:8] == {(DATA_W-8){ld_data[7]}}));

    p_unsigned_byte_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_store && req_size == 2'd0 && !ld_signed)
        |=> (ld_data[DATA_W-1:8] == '0));

endmodule

bind endian_lsu_aligner endian_lsu_aligner_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_store  (req_store),
    .req_size   (req_size),
    .ld_signed  (ld_signed),
    .big_endian (big_endian),
    .addr_lo    (addr_lo),
    .st_data    (st_data),
    .rd_word    (rd_word),
    .wr_word    (wr_word),
    .byte_en    (byte_en),
    .ld_data    (ld_data),
    .misalign   (misalign)
);

// File: tb/endian_lsu_aligner_bench.sv
module endian_lsu_aligner_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_store;
    logic [1:0]  req_size;
    logic        ld_signed;
    logic        big_endian;
    logic [1:0]  addr_lo;
    logic [31:0] st_data;
    logic [31:0] rd_word;
    logic [31:0] wr_word;
    logic [3:0]  byte_en;
    logic [31:0] ld_data;
    logic        misalign;

    always #5 clk = ~clk;

    endian_lsu_aligner u_endian_lsu_aligner (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_store  (req_store),
        .req_size   (req_size),
        .ld_signed  (ld_signed),
        .big_endian (big_endian),
        .addr_lo    (addr_lo),
        .st_data    (st_data),
        .rd_word    (rd_word),
        .wr_word    (wr_word),
        .byte_en    (byte_en),
        .ld_data    (ld_data),
        .misalign   (misalign)
    );

    typedef struct {
        logic [31:0] wr;
        logic [3:0]  be;
        logic [31:0] ld;
        logic        mis;
        string       tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [7:0] mem [16];
    int         checks = 0;
    int         errors = 0;
    bit         done   = 1'b0;

    // Behavioural model: walk the bytes of the access in address order.
    function automatic exp_t model(bit v, bit st, logic [1:0] sz, bit sg, bit bem,
                                   int off, logic [31:0] sd, logic [31:0] rw);
        exp_t        e;
        int          n;
        logic [31:0] val;
        e.wr = '0; e.be = '0; e.ld = '0; e.mis = 1'b0; e.tag = "";
        if (!v) return e;
        n = 1 << sz;
        if (sz == 2'd3 || (off % n) != 0) begin
            e.mis = 1'b1;
            return e;
        end
        val = '0;
        for (int k = 0; k < n; k++) begin
            int sig = bem ? (n - 1 - k) : k;
            if (st) begin
                e.wr[8*(off+k) +: 8] = sd[8*sig +: 8];
                e.be[off+k]          = 1'b1;
            end else begin
                val[8*sig +: 8] = rw[8*(off+k) +: 8];
            end
        end
        if (!st) begin
            for (int b = 8*n; b < 32; b++) val[b] = sg ? val[8*n-1] : 1'b0;
            e.ld = val;
        end
        return e;
    endfunction

    task automatic compare(exp_t e);
        checks++;
        if (wr_word !== e.wr || byte_en !== e.be || ld_data !== e.ld || misalign !== e.mis) begin
            errors++;
            $display("FAIL %s: actual wr=%h be=%b ld=%h mis=%b, expected wr=%h be=%b ld=%h mis=%b",
                     e.tag, wr_word, byte_en, ld_data, misalign, e.wr, e.be, e.ld, e.mis);
        end
    endtask

    task automatic lit(string tag, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h, expected %h", tag, act, expv);
        end
    endtask

    // Called on a falling edge: drive, predict, wait one clock, compare.
    task automatic op(bit v, bit st, logic [1:0] sz, bit sg, bit bem, int addr,
                      logic [31:0] sd, string tag);
        exp_t e;
        int   base = addr & ~3;
        int   off  = addr & 3;
        req_valid  = v;
        req_store  = st;
        req_size   = sz;
        ld_signed  = sg;
        big_endian = bem;
        addr_lo    = 2'(off);
        st_data    = sd;
        rd_word    = {mem[base+3], mem[base+2], mem[base+1], mem[base]};
        e          = model(v, st, sz, sg, bem, off, sd, rd_word);
        e.tag      = tag;
        exp_q.push_back(e);
        if (v && st && !e.mis) begin
            for (int i = 0; i < 4; i++) if (e.be[i]) mem[base+i] = e.wr[8*i +: 8];
        end
        @(negedge clk);
        compare(exp_q.pop_front());
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1: actual run still busy, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 8'h00;
        rst_n = 1'b0; req_valid = 1'b0; req_store = 1'b0; req_size = 2'd0;
        ld_signed = 1'b0; big_endian = 1'b0; addr_lo = 2'd0;
        st_data = 32'hFFFF_FFFF; rd_word = 32'hFFFF_FFFF;
        repeat (3) @(negedge clk);
        // R9: reset state
        lit("R9 reset wr_word", wr_word, 32'h0);
        lit("R9 reset byte_en", {28'h0, byte_en}, 32'h0);
        lit("R9 reset ld_data", ld_data, 32'h0);
        lit("R9 reset misalign", {31'h0, misalign}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 / R3 word placement
        op(1, 1, 2'd2, 0, 0, 0, 32'h12345678, "R2 LE word store");
        lit("R2 LE word lanes", wr_word, 32'h12345678);
        lit("R4 word store enables", {28'h0, byte_en}, 32'hF);
        op(1, 1, 2'd2, 0, 1, 4, 32'h12345678, "R3 BE word store");
        lit("R3 BE word lanes", wr_word, 32'h78563412);
        op(1, 0, 2'd1, 0, 1, 4, 32'h0, "R3 BE half load low");
        lit("R3 BE half at offset 0", ld_data, 32'h00001234);
        op(1, 0, 2'd1, 0, 1, 6, 32'h0, "R3 BE half load high");
        lit("R3 BE half at offset 2", ld_data, 32'h00005678);
        op(1, 0, 2'd1, 0, 0, 0, 32'h0, "R2 LE half load low");
        lit("R2 LE half at offset 0", ld_data, 32'h00005678);
        op(1, 0, 2'd1, 0, 0, 2, 32'h0, "R2 LE half load high");
        lit("R2 LE half at offset 2", ld_data, 32'h00001234);

        // R3: word 5 in big-endian, bytes at both ends
        op(1, 1, 2'd2, 0, 1, 8, 32'h5, "R3 BE store 5");
        op(1, 0, 2'd0, 0, 1, 8, 32'h0, "R3 BE byte load offset 0");
        lit("R3 byte at lowest address", ld_data, 32'h0);
        op(1, 0, 2'd0, 0, 1, 11, 32'h0, "R3 BE byte load offset 3");
        lit("R3 byte at highest address", ld_data, 32'h5);

        // R1 / R4: byte store and read-back in both modes
        op(1, 1, 2'd0, 0, 0, 14, 32'hAB_CD_EF_05, "R4 LE byte store");
        lit("R4 byte store single lane", {28'h0, byte_en}, 32'h4);
        lit("R1 byte in lane 2", wr_word, 32'h00050000);
        op(1, 0, 2'd0, 0, 0, 14, 32'h0, "R1 LE byte load back");
        lit("R1 LE byte read-back", ld_data, 32'h5);
        op(1, 1, 2'd0, 0, 1, 14, 32'h5, "R4 BE byte store");
        op(1, 0, 2'd0, 0, 1, 14, 32'h0, "R1 BE byte load back");
        lit("R1 BE byte read-back", ld_data, 32'h5);

        // R5 / R6: extension
        op(1, 1, 2'd1, 0, 1, 12, 32'h0000_8001, "R4 BE half store");
        lit("R4 half store enables", {28'h0, byte_en}, 32'h3);
        op(1, 0, 2'd1, 1, 1, 12, 32'h0, "R5 signed BE half");
        lit("R5 signed half", ld_data, 32'hFFFF8001);
        op(1, 0, 2'd1, 0, 1, 12, 32'h0, "R6 unsigned BE half");
        lit("R6 unsigned half", ld_data, 32'h00008001);
        op(1, 0, 2'd1, 1, 0, 12, 32'h0, "R5 signed LE half positive");
        lit("R5 positive half", ld_data, 32'h00000180);
        op(1, 0, 2'd0, 1, 0, 12, 32'h0, "R5 signed byte");
        lit("R5 signed byte", ld_data, 32'hFFFFFF80);
        op(1, 0, 2'd0, 0, 0, 12, 32'h0, "R6 unsigned byte");
        lit("R6 unsigned byte", ld_data, 32'h00000080);

        // R7: refused accesses leave memory untouched
        op(1, 1, 2'd1, 0, 0, 13, 32'hFFFF, "R7 odd half store");
        lit("R7 odd half flag", {31'h0, misalign}, 32'h1);
        lit("R7 odd half enables", {28'h0, byte_en}, 32'h0);
        op(1, 1, 2'd2, 0, 1, 14, 32'hFFFFFFFF, "R7 offset word store");
        lit("R7 offset word flag", {31'h0, misalign}, 32'h1);
        op(1, 1, 2'd3, 0, 0, 12, 32'hFFFFFFFF, "R7 illegal size");
        lit("R7 illegal size enables", {28'h0, byte_en}, 32'h0);
        op(1, 0, 2'd1, 1, 0, 5, 32'h0, "R7 odd half load");
        lit("R7 refused load data", ld_data, 32'h0);
        op(1, 0, 2'd2, 0, 0, 12, 32'h0, "R7 memory unchanged");
        lit("R7 word after refused stores", ld_data, 32'h00050180);

        // R8: idle and load cycles
        op(0, 1, 2'd2, 1, 1, 0, 32'hFFFFFFFF, "R8 idle cycle");
        lit("R8 idle wr_word", wr_word, 32'h0);
        op(1, 0, 2'd2, 0, 1, 0, 32'hFFFFFFFF, "R8 load no enables");
        lit("R8 load enables", {28'h0, byte_en}, 32'h0);

        // Back-to-back sweep of all offsets, sizes and modes
        for (int a = 0; a < 16; a++) begin
            for (int s = 0; s < 4; s++) begin
                for (int m = 0; m < 2; m++) begin
                    op(1, 1, 2'(s), 0, m[0], a, $urandom, "R1 sweep store");
                    op(1, 0, 2'(s), 1, m[0], a, 32'h0, "R5 sweep signed load");
                    op(1, 0, 2'(s), 0, ~m[0], a, 32'h0, "R6 sweep unsigned load");
                    if (((a + s) % 5) == 0) op(0, 0, 2'(s), 0, 0, a, 32'h0, "R8 sweep idle");
                end
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule